// File: doc/BRIEF.md
# UART Receive Queue with Per-Entry Line Status

This block is the receive half of a serial port. It watches the line on a 16x oversampling tick that an external divider supplies. It validates a start bit at mid-bit and collects five to eight data bits, least significant first. It then checks an optional parity bit and one or two stop bits. Each finished character goes into a 16-entry queue next to a four-flag status word that describes that character alone.

Software reads the head of the queue through two views. The status word comes first, and the data byte follows, because popping removes the entry. Occupancy is shown as a 4-bit count plus a separate full bit. Three interrupt sources sit in a write-one-to-clear status vector: the queue reaching a programmed level, a character that arrived with an error or was lost, and an idle line after the last character. The idle-line source fires whether or not the queue still holds data. Turning the receiver off, or pulsing the queue reset, empties the queue.

Top module: `uart_rx_fifo`

## Requirements
- R1: The character carries `dataCode`+5 data bits (code 0..3), sent least significant bit first, and `stopCode`+1 stop bits. The byte is right-aligned in `headData`, and its unused upper bits read zero.
- R2: `parityMode` selects the parity: 0 none, 1 even, 2 odd, 3 bit always one, 4 bit always zero. Codes 5 to 7 behave as none. A parity bit that differs from the expected value sets the parity flag of that entry.
- R3: `headErr` bit 0 is overrun, bit 1 is parity error, bit 2 is frame error and bit 3 is break. A stop bit sampled low sets the frame flag. If every data, parity and stop bit of the character is low, both break and frame are set.
- R4: Entries leave in arrival order. A `pop` pulse removes the head. While the queue is empty, `headData` and `headErr` read zero and a pop has no effect.
- R5: `fifoCount` holds the occupancy modulo 16. `fifoFull` is set at 16 entries, and `fifoCount` then reads 0.
- R6: A character that completes while the queue is full is discarded. The overrun flag then appears on the current head entry and stays there until that entry is popped. The error interrupt is raised as well.
- R7: A low level on the line that is gone by the eighth tick after it was detected is not treated as a start bit, and no entry is produced.
- R8: While `rxEnable` is low the receiver stays idle, any partial character is dropped, and the queue and any pending overrun are cleared.
- R9: A `fifoReset` pulse empties the queue.
- R10: The status bits of `irqStatus` are: bit 0 is set when a stored character leaves the occupancy at or above `trigLevel`; bit 1 is set by a stored character that has an error flag, or by an overrun; bit 2 is set once, 64 idle ticks (4 bit times) after the last completed character, even if the queue is empty.
- R11: Writing a one to a bit of `irqClear` clears that status bit. An event that arrives in the same cycle as the clear leaves the bit set. `irq` is high while any status bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | Oversampling strobe, 16 per bit time |
| rxLine | input | 1 | Serial receive line, idle high |
| rxEnable | input | 1 | Receiver on; low resets the receive path |
| fifoReset | input | 1 | Pulse that empties the queue |
| dataCode | input | 2 | Data bits minus five |
| stopCode | input | 1 | Stop bits minus one |
| parityMode | input | 3 | Parity selection |
| trigLevel | input | 4 | Occupancy level for the level interrupt |
| pop | input | 1 | Remove the head entry |
| headData | output | 8 | Data byte of the head entry |
| headErr | output | 4 | Status flags of the head entry |
| fifoCount | output | 4 | Occupancy modulo 16 |
| fifoFull | output | 1 | Queue holds 16 entries |
| irqClear | input | 3 | Write-one-to-clear strobes for `irqStatus` |
| irqStatus | output | 3 | Pending interrupt sources |
| irq | output | 1 | Any source pending |

## Verification
Two things can land on the same clock edge: the interrupt logic raising a source and software clearing it. The idle-line timeout is used to provoke this. A first run with no clear measures how many cycles after a tick-aligned character start the timeout bit rises. A second, identical run then drives the clear for that bit on exactly that edge, and the bit must read set afterwards. A discarded character and a pop of the entry that receives the overrun flag form a second such pair, judged by the flag reading set on the first entry read and clear on the second.

// File: rtl/uart_rxq_pkg.sv
`timescale 1ns/1ps
package uart_rxq_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    PAR_NONE = 3'd0,
    PAR_EVEN = 3'd1,
    PAR_ODD  = 3'd2,
    PAR_ONE  = 3'd3,
    PAR_ZERO = 3'd4
  } parity_e;

  // packed: brk is bit 3, overrun bit 0
  typedef struct packed {
    logic brk;
    logic frame;
    logic parity;
    logic overrun;
  } err_t;

  // control -> datapath strobes
  typedef struct packed {
    logic              push;
    logic              flush;
    logic [DATA_W-1:0] data;
    err_t              err;
  } strobe_t;

  // datapath -> control, registered events
  typedef struct packed {
    logic pushed;
    logic pushedErr;
    logic overrun;
  } dpEvent_t;
endpackage

// File: rtl/uart_rxq_datapath.sv
`timescale 1ns/1ps
module uart_rxq_datapath
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output err_t              headErr,
  output logic [CW-1:0]     count,
  output dpEvent_t          dpEv
);
  logic [DATA_W-1:0] dataMem [DEPTH];
  err_t              errMem  [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic              ovrPending;
  logic              isEmpty, isFull, popOk, pushOk, drop;

  assign isEmpty = (count == '0);
  assign isFull  = (count == CW'(DEPTH));
  assign popOk   = pop && !isEmpty;
  assign pushOk  = strobe.push && (!isFull || popOk);
  assign drop    = strobe.push && !pushOk;

  always_ff @(posedge clk) begin
    if (pushOk && !strobe.flush) begin
      dataMem[wrPtr] <= strobe.data;
      errMem[wrPtr]  <= strobe.err;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr      <= '0;
      rdPtr      <= '0;
      count      <= '0;
      ovrPending <= 1'b0;
      dpEv       <= '0;
    end else begin
      dpEv.pushed    <= pushOk && !strobe.flush;
      dpEv.pushedErr <= pushOk && !strobe.flush && (|strobe.err);
      dpEv.overrun   <= drop && !strobe.flush;
      if (strobe.flush) begin
        wrPtr      <= '0;
        rdPtr      <= '0;
        count      <= '0;
        ovrPending <= 1'b0;
      end else begin
        if (pushOk) wrPtr <= wrPtr + 1'b1;
        if (popOk)  rdPtr <= rdPtr + 1'b1;
        count <= count + CW'(pushOk) - CW'(popOk);
        if (drop)       ovrPending <= 1'b1;
        else if (popOk) ovrPending <= 1'b0;
      end
    end
  end

  always_comb begin
    headData = '0;
    headErr  = '0;
    if (!isEmpty) begin
      headData        = dataMem[rdPtr];
      headErr         = errMem[rdPtr];
      headErr.overrun = ovrPending;
    end
  end
endmodule

// File: rtl/uart_rxq_ctrl.sv
`timescale 1ns/1ps
module uart_rxq_ctrl
  import uart_rxq_pkg::*;
#(
  parameter int TOUT_BITS = 4,
  parameter int CW = 5,
  localparam int TOUT_TICKS = TOUT_BITS * 16,
  localparam int TW = $clog2(TOUT_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleTick,
  input  logic          rxLine,
  input  logic          rxEnable,
  input  logic          fifoReset,
  input  logic [1:0]    dataCode,
  input  logic          stopCode,
  input  logic [2:0]    parityMode,
  input  logic [CW-2:0] trigLevel,
  input  logic [2:0]    irqClear,
  input  logic [CW-1:0] count,
  input  dpEvent_t      dpEv,
  output strobe_t       strobe,
  output logic [2:0]    irqStatus
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} state_e;

  state_e            state;
  logic [1:0]        syncQ;
  logic              rxS;
  logic [3:0]        tickCnt;
  logic [2:0]        bitIdx;
  logic              stopIdx;
  logic [DATA_W-1:0] shReg;
  logic              parAcc, zeroAcc, stopLow, parErr;
  logic              parOn, parExp, midBit, frameDone, toutFire;
  logic [2:0]        lastBit;
  logic              armed;
  logic [TW-1:0]     toutCnt;
  logic [2:0]        events;

  assign rxS     = syncQ[1];
  assign lastBit = 3'(dataCode) + 3'd4;
  assign midBit  = sampleTick && (tickCnt == 4'd15);

  always_comb begin
    parOn  = 1'b1;
    parExp = 1'b0;
    unique case (parityMode)
      PAR_EVEN: parExp = parAcc;
      PAR_ODD:  parExp = ~parAcc;
      PAR_ONE:  parExp = 1'b1;
      PAR_ZERO: parExp = 1'b0;
      default:  parOn  = 1'b0;
    endcase
  end

  assign frameDone = rxEnable && midBit && (state == S_STOP) && (stopIdx == stopCode);

  always_comb begin
    strobe             = '0;
    strobe.flush       = !rxEnable || fifoReset;
    strobe.push        = frameDone;
    strobe.data        = shReg;
    strobe.err.parity  = parErr;
    strobe.err.frame   = stopLow | ~rxS;
    strobe.err.brk     = zeroAcc & ~rxS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      state   <= S_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      stopIdx <= 1'b0;
      shReg   <= '0;
      parAcc  <= 1'b0;
      zeroAcc <= 1'b1;
      stopLow <= 1'b0;
      parErr  <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rxLine};
      if (!rxEnable) begin
        state   <= S_IDLE;
        tickCnt <= '0;
      end else if (sampleTick) begin
        unique case (state)
          S_IDLE: if (!rxS) begin
            state   <= S_START;
            tickCnt <= '0;
          end
          S_START: if (tickCnt == 4'd7) begin
            tickCnt <= '0;
            if (rxS) state <= S_IDLE;
            else begin
              state   <= S_DATA;
              bitIdx  <= '0;
              stopIdx <= 1'b0;
              shReg   <= '0;
              parAcc  <= 1'b0;
              zeroAcc <= 1'b1;
              stopLow <= 1'b0;
              parErr  <= 1'b0;
            end
          end else tickCnt <= tickCnt + 1'b1;
          S_DATA: if (midBit) begin
            shReg[bitIdx] <= rxS;
            parAcc  <= parAcc ^ rxS;
            zeroAcc <= zeroAcc & ~rxS;
            tickCnt <= '0;
            if (bitIdx == lastBit) state <= parOn ? S_PAR : S_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else tickCnt <= tickCnt + 1'b1;
          S_PAR: if (midBit) begin
            parErr  <= (rxS != parExp);
            zeroAcc <= zeroAcc & ~rxS;
            tickCnt <= '0;
            state   <= S_STOP;
          end else tickCnt <= tickCnt + 1'b1;
          S_STOP: if (midBit) begin
            stopLow <= stopLow | ~rxS;
            zeroAcc <= zeroAcc & ~rxS;
            tickCnt <= '0;
            if (stopIdx == stopCode) state <= S_IDLE;
            else stopIdx <= 1'b1;
          end else tickCnt <= tickCnt + 1'b1;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // idle-line timer, restarted by each completed character
  assign toutFire = armed && sampleTick && (state == S_IDLE) &&
                    (toutCnt == TW'(TOUT_TICKS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      toutCnt <= '0;
    end else if (!rxEnable) begin
      armed   <= 1'b0;
      toutCnt <= '0;
    end else if (frameDone) begin
      armed   <= 1'b1;
      toutCnt <= '0;
    end else if (toutFire) begin
      armed <= 1'b0;
    end else if (armed && sampleTick && state == S_IDLE) begin
      toutCnt <= toutCnt + 1'b1;
    end
  end

  assign events[0] = dpEv.pushed && (count >= CW'(trigLevel));
  assign events[1] = dpEv.pushedErr || dpEv.overrun;
  assign events[2] = toutFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqStatus <= '0;
    else       irqStatus <= (irqStatus & ~irqClear) | events;
  end
endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TOUT_BITS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic              rxEnable,
  input  logic              fifoReset,
  input  logic [1:0]        dataCode,
  input  logic              stopCode,
  input  logic [2:0]        parityMode,
  input  logic [AW-1:0]     trigLevel,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic [3:0]        headErr,
  output logic [AW-1:0]     fifoCount,
  output logic              fifoFull,
  input  logic [2:0]        irqClear,
  output logic [2:0]        irqStatus,
  output logic              irq
);
  strobe_t       strobe;
  dpEvent_t      dpEv;
  err_t          headErrS;
  logic [CW-1:0] count;

  uart_rxq_ctrl #(.TOUT_BITS(TOUT_BITS), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .fifoReset(fifoReset), .dataCode(dataCode),
    .stopCode(stopCode), .parityMode(parityMode), .trigLevel(trigLevel),
    .irqClear(irqClear), .count(count), .dpEv(dpEv), .strobe(strobe),
    .irqStatus(irqStatus)
  );

  uart_rxq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pop(pop),
    .headData(headData), .headErr(headErrS), .count(count), .dpEv(dpEv)
  );

  assign headErr   = headErrS;
  assign fifoCount = count[CW-2:0];
  assign fifoFull  = count[CW-1];
  assign irq       = |irqStatus;
endmodule

// File: rtl/uart_rx_fifo_chk.sv
`timescale 1ns/1ps
module uart_rx_fifo_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          rxEnable,
  input logic          fifoReset,
  input logic [3:0]    headErr,
  input logic [AW-1:0] fifoCount,
  input logic          fifoFull,
  input logic [2:0]    irqClear,
  input logic [2:0]    irqStatus
);
  p_full_reads_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> (fifoCount == '0));

  p_disable_flush_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (fifoCount == '0 && !fifoFull && headErr == '0));

  p_fifo_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    fifoReset |=> (fifoCount == '0 && !fifoFull));

  p_overrun_on_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    headErr[0] |-> (fifoFull || fifoCount != '0));

  p_sticky_status_r11: assert property (@(posedge clk) disable iff (!rstN)
    (|(irqStatus & ~irqClear)) |=>
      ((irqStatus & $past(irqStatus & ~irqClear)) == $past(irqStatus & ~irqClear)));
endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fifoReset(fifoReset),
  .headErr(headErr), .fifoCount(fifoCount), .fifoFull(fifoFull),
  .irqClear(irqClear), .irqStatus(irqStatus)
);

// File: tb/uart_rx_fifo_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_test;
  logic       clk = 1'b0;
  logic       rstN, rxLine, rxEnable, fifoReset, stopCode, pop, fifoFull, irq;
  logic [1:0] dataCode;
  logic [2:0] parityMode, irqClear, irqStatus;
  logic [3:0] trigLevel, headErr, fifoCount;
  logic [7:0] headData;
  logic [1:0] tickPh = 2'd0;
  logic       sampleTick;
  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) tickPh <= tickPh + 2'd1;
  assign sampleTick = (tickPh == 2'd0);

  uart_rx_fifo uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .rxEnable(rxEnable), .fifoReset(fifoReset), .dataCode(dataCode),
    .stopCode(stopCode), .parityMode(parityMode), .trigLevel(trigLevel),
    .pop(pop), .headData(headData), .headErr(headErr), .fifoCount(fifoCount),
    .fifoFull(fifoFull), .irqClear(irqClear), .irqStatus(irqStatus), .irq(irq)
  );

  // {data, dataCode, stopCode, parityMode, badParity, badStop}
  localparam int NV = 13;
  localparam logic [15:0] VEC [NV] = '{
    {8'hA5, 2'd3, 1'b0, 3'd0, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b1, 3'd1, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b0, 3'd2, 1'b0, 1'b0},
    {8'h5A, 2'd3, 1'b0, 3'd1, 1'b1, 1'b0},
    {8'h1F, 2'd0, 1'b0, 3'd0, 1'b0, 1'b0},
    {8'hFF, 2'd1, 1'b0, 3'd3, 1'b0, 1'b0},
    {8'h7E, 2'd2, 1'b0, 3'd4, 1'b1, 1'b0},
    {8'h81, 2'd3, 1'b0, 3'd0, 1'b0, 1'b1},
    {8'h00, 2'd3, 1'b0, 3'd0, 1'b0, 1'b1},
    {8'h00, 2'd3, 1'b0, 3'd4, 1'b0, 1'b1},
    {8'h96, 2'd3, 1'b1, 3'd5, 1'b0, 1'b0},
    {8'h00, 2'd3, 1'b0, 3'd1, 1'b0, 1'b1},
    {8'h01, 2'd3, 1'b0, 3'd2, 1'b0, 1'b1}
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
    end
  endtask

  function automatic logic [7:0] maskOf(input int nData);
    return 8'((1 << nData) - 1);
  endfunction

  function automatic bit parOn(input int pm);
    return (pm >= 1 && pm <= 4);
  endfunction

  function automatic logic parBit(input logic [7:0] d, input int nData, input int pm);
    logic x;
    x = ^(d & maskOf(nData));
    case (pm)
      1: return x;
      2: return ~x;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // bit3 break, bit2 frame, bit1 parity, bit0 overrun
  function automatic logic [3:0] expErr(input logic [7:0] d, input int nData,
                                        input int pm, input bit badPar, input bit badStop);
    logic pb, brk;
    pb  = parBit(d, nData, pm) ^ badPar;
    brk = badStop && ((d & maskOf(nData)) == 8'h00) && (!parOn(pm) || pb == 1'b0);
    return {brk, badStop, badPar && parOn(pm), 1'b0};
  endfunction

  task automatic alignTick();
    @(negedge clk);
    while (tickPh != 2'd1) @(negedge clk);
  endtask

  task automatic lineFor(input logic v, input int n);
    rxLine = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nData, input int pm,
                           input bit badPar, input int nStop, input bit badStop);
    if (tickPh != 2'd1) alignTick();
    lineFor(1'b0, 64);
    for (int i = 0; i < nData; i++) lineFor(d[i], 64);
    if (parOn(pm)) lineFor(parBit(d, nData, pm) ^ badPar, 64);
    for (int i = 0; i < nStop; i++)
      lineFor(~badStop, (badStop && i == nStop - 1) ? 40 : 64);
    lineFor(1'b1, 64);
  endtask

  task automatic send8n1(input logic [7:0] d);
    dataCode = 2'd3; stopCode = 1'b0; parityMode = 3'd0;
    sendFrame(d, 8, 0, 1'b0, 1, 1'b0);
  endtask

  task automatic popOne();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic clearAll();
    irqClear = 3'b111;
    @(negedge clk);
    irqClear = 3'b000;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic [1:0] dc;
    logic       sc, bp, bs;
    logic [2:0] pm;
    int         rise, t0;

    rstN = 1'b0; rxLine = 1'b1; rxEnable = 1'b1; fifoReset = 1'b0;
    dataCode = 2'd3; stopCode = 1'b0; parityMode = 3'd0; trigLevel = 4'd0;
    pop = 1'b0; irqClear = 3'b000;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R5 reset count", fifoCount, 0);
    chk("R5 reset full", fifoFull, 0);
    chk("R11 reset status", irqStatus, 0);
    chk("R11 reset irq", irq, 0);
    chk("R4 empty head error", headErr, 0);

    // table of frame formats
    for (int v = 0; v < NV; v++) begin
      {d, dc, sc, pm, bp, bs} = VEC[v];
      dataCode = dc; stopCode = sc; parityMode = pm;
      sendFrame(d, int'(dc) + 5, int'(pm), bp, int'(sc) + 1, bs);
      chk($sformatf("R1 vec%0d count", v), fifoCount, 1);
      chk($sformatf("R1 vec%0d data", v), headData, d & maskOf(int'(dc) + 5));
      chk($sformatf("R2 R3 vec%0d flags", v), headErr,
          expErr(d, int'(dc) + 5, int'(pm), bp, bs));
      popOne();
      chk($sformatf("R4 vec%0d pop empties", v), fifoCount, 0);
    end

    // pop on empty has no effect
    popOne();
    chk("R4 pop on empty count", fifoCount, 0);
    chk("R4 pop on empty full", fifoFull, 0);

    // fill and overrun
    clearAll();
    for (int i = 0; i < 16; i++) send8n1(8'h10 + 8'(i));
    chk("R5 full count field", fifoCount, 0);
    chk("R5 full flag", fifoFull, 1);
    chk("R6 no overrun before loss", headErr[0], 0);
    send8n1(8'hEE);
    chk("R5 still full", fifoFull, 1);
    chk("R6 overrun on head", headErr[0], 1);
    chk("R6 error interrupt", irqStatus[1], 1);
    chk("R11 irq line", irq, 1);
    for (int i = 0; i < 16; i++) begin
      chk($sformatf("R4 order entry %0d", i), headData, 8'h10 + 8'(i));
      chk($sformatf("R6 overrun entry %0d", i), headErr[0], (i == 0) ? 1 : 0);
      popOne();
    end
    chk("R4 drained", {fifoFull, fifoCount}, 0);

    // level interrupt
    trigLevel = 4'd3;
    clearAll();
    send8n1(8'h21);
    send8n1(8'h22);
    chk("R10 below level", irqStatus[0], 0);
    send8n1(8'h23);
    chk("R10 at level", irqStatus[0], 1);
    repeat (3) popOne();
    trigLevel = 4'd0;

    // timeout with empty queue
    send8n1(8'h31);
    popOne();
    clearAll();
    chk("R10 timeout not yet", irqStatus[2], 0);
    repeat (400) @(negedge clk);
    chk("R10 timeout with empty queue", irqStatus[2], 1);
    chk("R10 queue empty at timeout", fifoCount, 0);
    clearAll();
    repeat (600) @(negedge clk);
    chk("R10 timeout once per frame", irqStatus[2], 0);

    // set and clear on the same edge
    clearAll();
    alignTick();
    t0 = cyc;
    send8n1(8'h41);
    popOne();
    rise = -1;
    for (int i = 0; i < 2000 && rise < 0; i++) begin
      if (irqStatus[2]) rise = cyc - t0;
      else @(negedge clk);
    end
    chk("R10 timeout observed", (rise > 0) ? 1 : 0, 1);
    repeat (600) @(negedge clk);
    clearAll();
    alignTick();
    t0 = cyc;
    send8n1(8'h42);
    popOne();
    while (cyc - t0 < rise - 1) @(negedge clk);
    chk("R11 status low before event", irqStatus[2], 0);
    irqClear = 3'b100;
    @(negedge clk);
    irqClear = 3'b000;
    @(negedge clk);
    chk("R11 event beats clear", irqStatus[2], 1);
    clearAll();

    // receiver disable
    send8n1(8'h51);
    send8n1(8'h52);
    chk("R8 two stored", fifoCount, 2);
    rxEnable = 1'b0;
    @(negedge clk);
    rxEnable = 1'b1;
    chk("R8 disable empties", fifoCount, 0);
    chk("R8 head cleared", headErr, 0);

    // queue reset
    send8n1(8'h61);
    fifoReset = 1'b1;
    @(negedge clk);
    fifoReset = 1'b0;
    chk("R9 reset empties", fifoCount, 0);
    chk("R9 reset head data", headData, 0);

    // short glitch then a clean frame
    alignTick();
    lineFor(1'b0, 16);
    lineFor(1'b1, 300);
    chk("R7 glitch ignored", fifoCount, 0);
    send8n1(8'h7C);
    chk("R7 clean frame after glitch", headData, 8'h7C);
    chk("R7 clean flags", headErr, 0);
    popOne();

    summary();
  end
endmodule